// File: doc/BRIEF.md
# Byte Permute and Window Extract Unit

This datapath handles 128-bit vectors as sixteen byte lanes and performs one of two byte-level rearrangements per transaction. A one-bit opcode selects the operation. In the table-driven permute, each output lane reads its own control byte. That byte either forces the lane to zero or names any lane of the data vector to copy. In the window extract, two vectors are joined into one double-width value. A byte-granular right shift then takes a 16-byte slice from it. The shift count comes from an 8-bit immediate.

A narrow mode restricts both operations to the low eight lanes of each operand. In this mode the upper half of the result reads as zero. The result is registered by default and comes with a valid strobe that follows the input strobe one cycle later. A parameter can remove the register so that the path is purely combinational. Lane 0 always occupies bits [7:0], and each higher lane sits eight bits further up.

Top module: `byte_perm_unit`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `result` is all zeros.
- R2: With the default registered output, `out_valid` equals `in_valid` of the previous clock. `result` takes the new value at that edge and keeps it unchanged while `in_valid` is low.
- R3: With `op`=0 (permute) and `narrow`=0, control byte k is `vec_b[8k+7:8k]`. When its bit 7 is 0, result lane k equals `vec_a` lane s, where s = control bits [3:0]. Lane n means bits [8n+7:8n].
- R4: In permute, a control byte with bit 7 = 1 makes its result lane 0x00, whatever its other bits hold.
- R5: Control bits [6:4] do not affect the permute result.
- R6: With `op`=0 and `narrow`=1, result lanes 0..7 follow R3 and R4, with s = control bits [2:0] and bit 3 ignored. Result lanes 8..15 are 0x00.
- R7: With `op`=1 (extract) and `narrow`=0, the 32-byte value {`vec_a`,`vec_b`} is formed, with `vec_b` in the low half. It is shifted right by `imm` bytes, and the low 16 bytes form the result. When `imm`=0 the result equals `vec_b`.
- R8: In wide extract with `imm` from 16 to 31, the result holds `vec_a` lanes `imm`-16 upward, and the vacated top lanes are filled with zeros. With `imm` of 32 or more, the result is zero.
- R9: With `op`=1 and `narrow`=1, the 16-byte value {`vec_a`[63:0],`vec_b`[63:0]} is shifted right by `imm` bytes. Its low 8 bytes form result lanes 0..7, and lanes 8..15 are zero. With `imm` of 16 or more, the whole result is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and opcode are valid this cycle |
| op | input | 1 | 0 = byte permute, 1 = window extract |
| narrow | input | 1 | 1 = operate on the low 8 lanes only |
| vec_a | input | 128 | Data vector / upper half of extract concatenation |
| vec_b | input | 128 | Control vector (permute) / lower half of extract concatenation |
| imm | input | 8 | Byte shift count for extract |
| out_valid | output | 1 | Result valid strobe |
| result | output | 128 | Operation result |

## Verification
The hardest cases to reach are those where a control byte carries stray bits: reserved bits [6:4] set, bit 3 set in narrow mode, or bit 7 set while the lane selector points somewhere meaningful. Random stimulus seldom isolates these, so the bench builds control vectors that deliberately set the ignored bits over a known identity or reversal pattern. Any leakage then shows up as a wrong source lane. The shift count is swept across the boundaries 0, 15, 16, 31 and 32 in wide mode, and 7, 8, 15 and 16 in narrow mode. Idle cycles with the operands changing confirm that the result is held.

// File: rtl/bpa_pkg.sv
package bpa_pkg;
  typedef enum logic {
    OP_PERMUTE = 1'b0,
    OP_EXTRACT = 1'b1
  } bpa_op_e;

  localparam int BYTE_W = 8;
endpackage

// File: rtl/bpa_perm_lane.sv
module bpa_perm_lane #(
  parameter int LANES  = 16,
  parameter int LANE_W = bpa_pkg::BYTE_W,
  parameter int IDX    = 0
) (
  input  logic [LANES*LANE_W-1:0] src,
  input  logic [LANE_W-1:0]       ctrl,
  input  logic                    narrow,
  output logic [LANE_W-1:0]       dout,
  output logic                    zeroed
);
  localparam int VEC_W = LANES * LANE_W;
  localparam int SEL_W = $clog2(LANES);
  localparam int HALF  = LANES / 2;
  localparam bit UPPER = (IDX >= HALF);

  // Selector width depends on mode: narrow drops the top selector bit.
  function automatic logic [SEL_W-1:0] lane_select(input logic [LANE_W-1:0] c,
                                                   input logic nar);
    logic [SEL_W-1:0] s;
    s = c[SEL_W-1:0];
    if (nar) s[SEL_W-1] = 1'b0;
    return s;
  endfunction

  function automatic logic [LANE_W-1:0] pick_lane(input logic [VEC_W-1:0] v,
                                                  input logic [SEL_W-1:0] s);
    return v[int'(s)*LANE_W +: LANE_W];
  endfunction

  logic [SEL_W-1:0] sel;
  logic             kill_bit;
  logic             kill_mode;

  assign sel       = lane_select(ctrl, narrow);
  assign kill_bit  = ctrl[LANE_W-1];
  assign kill_mode = narrow && UPPER;
  assign zeroed    = kill_bit | kill_mode;
  assign dout      = zeroed ? '0 : pick_lane(src, sel);
endmodule

// File: rtl/bpa_extract.sv
module bpa_extract #(
  parameter int LANES  = 16,
  parameter int LANE_W = bpa_pkg::BYTE_W,
  parameter int IMM_W  = 8
) (
  input  logic [LANES*LANE_W-1:0] hi_vec,
  input  logic [LANES*LANE_W-1:0] lo_vec,
  input  logic [IMM_W-1:0]        count,
  input  logic                    narrow,
  output logic [LANES*LANE_W-1:0] dout
);
  localparam int VEC_W  = LANES * LANE_W;
  localparam int HALF_W = VEC_W / 2;
  localparam int SH_W   = IMM_W + $clog2(LANE_W) + 1;

  // Byte count to bit count, wide enough that no count wraps.
  function automatic logic [SH_W-1:0] bit_shift(input logic [IMM_W-1:0] c);
    return SH_W'(c) * SH_W'(LANE_W);
  endfunction

  logic [SH_W-1:0]    shamt;
  logic [2*VEC_W-1:0] cat_wide;
  logic [2*VEC_W-1:0] cat_narrow;
  logic [2*VEC_W-1:0] sh_wide;
  logic [2*VEC_W-1:0] sh_narrow;

  assign shamt      = bit_shift(count);
  assign cat_wide   = {hi_vec, lo_vec};
  assign cat_narrow = {{VEC_W{1'b0}}, hi_vec[HALF_W-1:0], lo_vec[HALF_W-1:0]};
  assign sh_wide    = cat_wide >> shamt;
  assign sh_narrow  = cat_narrow >> shamt;

  always_comb begin
    if (narrow) dout = {{HALF_W{1'b0}}, sh_narrow[HALF_W-1:0]};
    else        dout = sh_wide[VEC_W-1:0];
  end
endmodule

// File: rtl/bpa_out_stage.sv
module bpa_out_stage #(
  parameter int  VEC_W      = 128,
  parameter bit  REGISTERED = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [VEC_W-1:0] din,
  output logic             out_valid,
  output logic [VEC_W-1:0] dout
);
  generate
    if (REGISTERED) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          out_valid <= 1'b0;
          dout      <= '0;
        end else begin
          out_valid <= in_valid;
          if (in_valid) dout <= din;
        end
      end
    end else begin : g_comb
      logic unused_clk_rst;
      assign unused_clk_rst = clk ^ rst_n;
      assign out_valid = rst_n & in_valid;
      assign dout      = rst_n ? din : '0;
    end
  endgenerate
endmodule

// File: rtl/byte_perm_unit.sv
module byte_perm_unit #(
  parameter int LANES      = 16,
  parameter int IMM_W      = 8,
  parameter bit REGISTERED = 1'b1
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               in_valid,
  input  logic                               op,
  input  logic                               narrow,
  input  logic [LANES*bpa_pkg::BYTE_W-1:0]   vec_a,
  input  logic [LANES*bpa_pkg::BYTE_W-1:0]   vec_b,
  input  logic [IMM_W-1:0]                   imm,
  output logic                               out_valid,
  output logic [LANES*bpa_pkg::BYTE_W-1:0]   result
);
  import bpa_pkg::*;

  localparam int LANE_W = BYTE_W;
  localparam int VEC_W  = LANES * LANE_W;

  bpa_op_e          op_e;
  logic [VEC_W-1:0] perm_result;
  logic [VEC_W-1:0] extract_result;
  logic [VEC_W-1:0] next_result;
  logic [LANES-1:0] lane_zero;

  assign op_e = bpa_op_e'(op);

  generate
    for (genvar k = 0; k < LANES; k++) begin : g_lane
      bpa_perm_lane #(
        .LANES (LANES),
        .LANE_W(LANE_W),
        .IDX   (k)
      ) u_lane (
        .src   (vec_a),
        .ctrl  (vec_b[k*LANE_W +: LANE_W]),
        .narrow(narrow),
        .dout  (perm_result[k*LANE_W +: LANE_W]),
        .zeroed(lane_zero[k])
      );
    end
  endgenerate

  bpa_extract #(
    .LANES (LANES),
    .LANE_W(LANE_W),
    .IMM_W (IMM_W)
  ) u_extract (
    .hi_vec(vec_a),
    .lo_vec(vec_b),
    .count (imm),
    .narrow(narrow),
    .dout  (extract_result)
  );

  assign next_result = (op_e == OP_EXTRACT) ? extract_result : perm_result;

  bpa_out_stage #(
    .VEC_W     (VEC_W),
    .REGISTERED(REGISTERED)
  ) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .din      (next_result),
    .out_valid(out_valid),
    .dout     (result)
  );
endmodule

// File: rtl/bpa_checker.sv
module bpa_checker #(
  parameter int LANES      = 16,
  parameter int IMM_W      = 8,
  parameter bit REGISTERED = 1'b1
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     in_valid,
  input logic                     op,
  input logic                     narrow,
  input logic [LANES*8-1:0]       vec_a,
  input logic [LANES*8-1:0]       vec_b,
  input logic [IMM_W-1:0]         imm,
  input logic                     out_valid,
  input logic [LANES*8-1:0]       result,
  input logic [LANES-1:0]         lane_zero,
  input logic [LANES*8-1:0]       extract_result
);
  localparam int VEC_W  = LANES * 8;
  localparam int HALF_W = VEC_W / 2;

  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  logic unused_vec_a;
  assign unused_vec_a = ^vec_a;

  always @(posedge clk) begin
    if (rst_n && narrow && (int'(imm) >= LANES))
      AST_NARROW_FAR_ZERO: assert (extract_result == '0); // R9
  end

  always @(negedge clk) begin
    if (!rst_n)
      AST_RESET_QUIET: assert (!out_valid && result == '0); // R1
  end

  generate
    if (REGISTERED) begin : g_seq
      AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (out_valid == $past(in_valid))); // R2
      AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(in_valid)) |-> $stable(result)); // R2
      AST_KILL_LANE0: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == bpa_pkg::OP_PERMUTE && lane_zero[0]) |=> (result[7:0] == 8'h00)); // R4
      AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && narrow) |=> (result[VEC_W-1:HALF_W] == '0)); // R6
      AST_EXTRACT_FAR: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == bpa_pkg::OP_EXTRACT && !narrow && int'(imm) >= 2*LANES) |=> (result == '0)); // R8
      AST_EXTRACT_IDENT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == bpa_pkg::OP_EXTRACT && !narrow && imm == '0) |=> (result == $past(vec_b))); // R7
    end
  endgenerate
endmodule

bind byte_perm_unit bpa_checker #(
  .LANES     (LANES),
  .IMM_W     (IMM_W),
  .REGISTERED(REGISTERED)
) u_bpa_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_valid      (in_valid),
  .op            (op),
  .narrow        (narrow),
  .vec_a         (vec_a),
  .vec_b         (vec_b),
  .imm           (imm),
  .out_valid     (out_valid),
  .result        (result),
  .lane_zero     (lane_zero),
  .extract_result(extract_result)
);

// File: tb/byte_perm_unit_test.sv
module byte_perm_unit_test;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic         op;
  logic         narrow;
  logic [127:0] vec_a;
  logic [127:0] vec_b;
  logic [7:0]   imm;
  logic         out_valid;
  logic [127:0] result;

  int    n_checks = 0;
  int    n_fail   = 0;
  bit    done     = 1'b0;
  string cur_tag  = "R2";

  logic         exp_valid  = 1'b0;
  logic [127:0] exp_result = '0;
  string        exp_tag    = "R1";

  always #10 clk = ~clk;

  byte_perm_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .narrow(narrow),
    .vec_a(vec_a), .vec_b(vec_b), .imm(imm), .out_valid(out_valid), .result(result)
  );

  // Behavioural reference: lane-by-lane, with the extract written as a window read.
  function automatic logic [127:0] ref_calc(input bit o, input bit nar,
      input logic [127:0] a, input logic [127:0] b, input logic [7:0] cnt);
    logic [127:0] r;
    int n;
    r = '0;
    n = nar ? 8 : 16;
    for (int k = 0; k < n; k++) begin
      if (!o) begin
        logic [7:0] c;
        int s;
        c = b[8*k +: 8];
        if (!c[7]) begin
          s = nar ? int'(c[2:0]) : int'(c[3:0]);
          r[8*k +: 8] = a[8*s +: 8];
        end
      end else begin
        int idx;
        idx = k + int'(cnt);
        if (idx < n)          r[8*k +: 8] = b[8*idx +: 8];
        else if (idx < 2 * n) r[8*k +: 8] = a[8*(idx-n) +: 8];
      end
    end
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_valid  <= 1'b0;
      exp_result <= '0;
      exp_tag    <= "R1";
    end else begin
      exp_valid <= in_valid;
      if (in_valid) begin
        exp_result <= ref_calc(op, narrow, vec_a, vec_b, imm);
        exp_tag    <= cur_tag;
      end else begin
        exp_tag <= "R2";
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      n_checks++;
      if (out_valid !== exp_valid || result !== exp_result) begin
        n_fail++;
        $display("FAIL %s: out_valid=%0b result=%032h expected out_valid=%0b result=%032h",
                 exp_tag, out_valid, result, exp_valid, exp_result);
      end
    end
  end

  task automatic issue(input string tag, input bit o, input bit nar,
                       input logic [127:0] a, input logic [127:0] b, input logic [7:0] cnt);
    @(negedge clk);
    cur_tag  = tag;
    in_valid = 1'b1;
    op       = o;
    narrow   = nar;
    vec_a    = a;
    vec_b    = b;
    imm      = cnt;
  endtask

  task automatic idle(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      op       = 1'($urandom);
      narrow   = 1'($urandom);
      vec_a    = {$urandom, $urandom, $urandom, $urandom};
      vec_b    = {$urandom, $urandom, $urandom, $urandom};
      imm      = 8'($urandom);
    end
  endtask

  function automatic logic [127:0] ctrl_pattern(input int kind, input logic [7:0] orv);
    logic [127:0] v;
    for (int k = 0; k < 16; k++) begin
      logic [7:0] c;
      case (kind)
        0: c = 8'(k);
        1: c = 8'(15 - k);
        2: c = 8'(5);
        default: c = 8'(k ^ 3);
      endcase
      v[8*k +: 8] = c | orv;
    end
    return v;
  endfunction

  localparam logic [127:0] DATA_A = 128'hF0E1D2C3B4A5968778695A4B3C2D1E0F;
  localparam logic [127:0] DATA_B = 128'h0123456789ABCDEF_FEDCBA9876543210;

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; op = 1'b0; narrow = 1'b0;
    vec_a = '0; vec_b = '0; imm = '0;
    repeat (3) @(negedge clk);  // R1: reset state compared each cycle
    rst_n = 1'b1;

    // R3: identity, reversal, broadcast, xor pattern
    issue("R3", 0, 0, DATA_A, ctrl_pattern(0, 8'h00), 0);
    issue("R3", 0, 0, DATA_A, ctrl_pattern(1, 8'h00), 0);
    issue("R3", 0, 0, DATA_A, ctrl_pattern(2, 8'h00), 0);
    issue("R3", 0, 0, DATA_A, ctrl_pattern(3, 8'h00), 0);
    // R4: kill bit, all lanes and alternating lanes
    issue("R4", 0, 0, DATA_A, ctrl_pattern(0, 8'h80), 0);
    issue("R4", 0, 0, DATA_A, 128'h80_07_8F_05_FF_03_82_01_80_0E_8D_0C_8B_0A_89_08, 0);
    // R5: reserved bits set on top of known patterns
    issue("R5", 0, 0, DATA_A, ctrl_pattern(0, 8'h70), 0);
    issue("R5", 0, 0, DATA_A, ctrl_pattern(1, 8'h50), 0);
    issue("R5", 0, 0, DATA_A, ctrl_pattern(3, 8'h20), 0);
    // R6: narrow permute, bit 3 set must not reach upper lanes
    issue("R6", 0, 1, DATA_A, ctrl_pattern(0, 8'h08), 0);
    issue("R6", 0, 1, DATA_A, ctrl_pattern(1, 8'h78), 0);
    issue("R6", 0, 1, DATA_A, ctrl_pattern(0, 8'h80), 0);
    idle(3);  // R2: hold while idle
    // R7: wide extract within the low operand
    issue("R7", 1, 0, DATA_A, DATA_B, 0);
    issue("R7", 1, 0, DATA_A, DATA_B, 5);
    issue("R7", 1, 0, DATA_A, DATA_B, 15);
    // R8: upper operand region and beyond
    issue("R8", 1, 0, DATA_A, DATA_B, 16);
    issue("R8", 1, 0, DATA_A, DATA_B, 20);
    issue("R8", 1, 0, DATA_A, DATA_B, 31);
    issue("R8", 1, 0, DATA_A, DATA_B, 32);
    issue("R8", 1, 0, DATA_A, DATA_B, 255);
    // R9: narrow extract
    issue("R9", 1, 1, DATA_A, DATA_B, 0);
    issue("R9", 1, 1, DATA_A, DATA_B, 3);
    issue("R9", 1, 1, DATA_A, DATA_B, 7);
    issue("R9", 1, 1, DATA_A, DATA_B, 8);
    issue("R9", 1, 1, DATA_A, DATA_B, 15);
    issue("R9", 1, 1, DATA_A, DATA_B, 16);
    idle(2);  // R2
    for (int i = 0; i < 300; i++) begin
      issue("R3", 1'($urandom), 1'($urandom),
            {$urandom, $urandom, $urandom, $urandom},
            {$urandom, $urandom, $urandom, $urandom}, 8'($urandom % 40));
      if ((i % 7) == 0) idle(1);
    end
    idle(3);
    @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule